// File: doc/BRIEF.md
# Shared SRAM Access Controller with Per-Port Address Generators

This block lets several processor ports share one single-ported SRAM of 8192 sixteen-bit words (16 KB). Each port hands in a read or a write. The request is latched by a small per-port state machine and waits there until a fixed-priority arbiter grants it. The arbiter gives out exactly one memory access per clock. Write data, address and the write strobe of the winning port are steered onto the SRAM pins. Read data comes back on that port one cycle later.

Every port carries its own address generator, so a processor can stream through a buffer without computing addresses. There are three modes. In direct mode the address travels with the request. Stride mode walks from a base address by a programmable step. Ring mode walks the same way but folds back inside a programmable buffer length. The generator registers and the port's arbitration priority are loaded through a per-port configuration strobe that only takes effect while the port is idle. The SRAM itself sits outside the block; all ports and the memory run on one clock.

Each port's state machine has three states. PS_IDLE goes to PS_PEND when a request is accepted. PS_PEND stays put until the port is granted. On the grant, a write returns to PS_IDLE and a read moves to PS_RDATA. PS_RDATA is the read-return cycle and always goes back to PS_IDLE.

Top module: `shmem_ctrl`

## Requirements
- R1: After reset, busy, gnt and rd_valid are zero and mem_en is low. Every port is in direct mode with base, stride, length, offset and priority all zero.
- R2: A request with req_valid high on an idle port is accepted at the clock edge, and busy is high from the next cycle. At most one bit of gnt is high in any cycle, and mem_en is high exactly in the cycles that carry a grant.
- R3: Among the pending ports, the one with the largest priority value is granted; on a tie the lowest port index wins. With the reset priorities of zero, port 0 comes first.
- R4: In a grant cycle, mem_we equals the granted request's write flag, and for a write mem_wdata equals its data.
- R5: In mode code 0 (direct) and the reserved code 3, mem_addr equals the req_addr latched with the request.
- R6: In mode code 1 (stride), mem_addr is (base + offset) mod 8192. After each grant the offset becomes (offset + stride) mod 8192.
- R7: In mode code 2 (ring), mem_addr is (base + offset) mod 8192. After each grant the offset becomes offset + stride, minus length when that sum is at least length. A length of zero keeps the offset at zero.
- R8: A pending request that is not granted leaves its generator's offset unchanged, so the address it finally uses is the one computed when it was accepted.
- R9: A granted read raises rd_valid of that port only, in the cycle right after the grant, with rd_data equal to mem_rdata. rd_data of every port is zero whenever its rd_valid is low.
- R10: A configuration strobe writes the field chosen by cfg_sel: 0 mode (bits 1:0), 1 base, 2 stride, 3 length (bits 12:0), and 4 priority (bits 1:0). Codes 5 to 7 do nothing. Writing mode or base clears the offset. The strobe is ignored when the port is busy or when req_valid is high in the same cycle.
- R11: After a write grant, busy drops in the next cycle. After a read grant, busy stays high through the data cycle and drops after it.
- R12: req_valid on a busy port is ignored: it does not create a second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports and the SRAM |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NP | Per-port request strobe |
| req_write | input | NP | Per-port write (1) or read (0) |
| req_addr | input | NP*AW | Per-port address, used in direct mode |
| req_wdata | input | NP*DW | Per-port write data |
| cfg_we | input | NP | Per-port configuration strobe |
| cfg_sel | input | NP*3 | Per-port field select for configuration |
| cfg_wdata | input | NP*DW | Per-port configuration value |
| busy | output | NP | Port holds an unfinished request |
| gnt | output | NP | One-hot grant for the current cycle |
| rd_valid | output | NP | Read data valid for that port |
| rd_data | output | NP*DW | Per-port read data, zero when not valid |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW | SRAM word address |
| mem_wdata | output | DW | SRAM write data |
| mem_rdata | input | DW | SRAM read data, one cycle after the access |

## Verification
The hardest situation to reach is a request that has waited several cycles behind higher-priority ports while a configuration strobe and a second request strobe hit that same port. The final address then shows whether the offset held still and whether both strobes were dropped. The bench fires all four ports in one cycle with generators set to distinct bases. It injects the ignored strobes in a cycle where the lowest-priority ports are still pending, then compares the later addresses against a behavioural model. A long random phase mixes requests, reprogrammed priorities, zero ring lengths and configuration strobes that coincide with requests.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam int CFG_SEL_W = 3;

    typedef enum logic [1:0] {
        AM_DIRECT = 2'd0,
        AM_STRIDE = 2'd1,
        AM_RING   = 2'd2,
        AM_RSVD   = 2'd3
    } amode_t;

    typedef enum logic [CFG_SEL_W-1:0] {
        CF_MODE   = 3'd0,
        CF_BASE   = 3'd1,
        CF_STRIDE = 3'd2,
        CF_LENGTH = 3'd3,
        CF_PRIO   = 3'd4
    } cfsel_t;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_PEND  = 2'd1,
        PS_RDATA = 2'd2
    } pstate_t;

endpackage

// File: rtl/smc_port.sv
module smc_port
    import smc_pkg::*;
#(
    parameter int AW = 13,
    parameter int DW = 16,
    parameter int PW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [AW-1:0]        req_addr,
    input  logic [DW-1:0]        req_wdata,
    input  logic                 cfg_we,
    input  logic [CFG_SEL_W-1:0] cfg_sel,
    input  logic [DW-1:0]        cfg_wdata,
    input  logic                 grant,
    output logic                 pending,
    output logic                 busy,
    output logic                 rd_valid,
    output logic                 op_write,
    output logic [AW-1:0]        op_addr,
    output logic [DW-1:0]        op_wdata,
    output logic [PW-1:0]        prio
);

    pstate_t         state_q, state_d;
    logic            wr_q;
    logic [AW-1:0]   dir_q;
    logic [DW-1:0]   wd_q;
    amode_t          mode_q;
    logic [AW-1:0]   base_q, stride_q, len_q, off_q, off_nx;
    logic [PW-1:0]   prio_q;
    logic [AW:0]     sum;
    logic [AW-1:0]   folded;
    logic            accept, cfg_ok, advance;
    logic            unused_cfg_bits;

    assign accept  = (state_q == PS_IDLE) && req_valid;
    assign cfg_ok  = (state_q == PS_IDLE) && cfg_we && !req_valid;
    assign advance = (state_q == PS_PEND) && grant;
    assign unused_cfg_bits = ^cfg_wdata[DW-1:AW];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:  if (req_valid) state_d = PS_PEND;
            PS_PEND:  if (grant) state_d = wr_q ? PS_IDLE : PS_RDATA;
            PS_RDATA: state_d = PS_IDLE;
            default:  state_d = PS_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        pending  = 1'b0;
        busy     = 1'b0;
        rd_valid = 1'b0;
        unique case (state_q)
            PS_IDLE:  ;
            PS_PEND:  begin pending = 1'b1; busy = 1'b1; end
            PS_RDATA: begin rd_valid = 1'b1; busy = 1'b1; end
            default:  ;
        endcase
    end

    // latched request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= 1'b0;
            dir_q <= '0;
            wd_q  <= '0;
        end else if (accept) begin
            wr_q  <= req_write;
            dir_q <= req_addr;
            wd_q  <= req_wdata;
        end
    end

    // generator registers and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= AM_DIRECT;
            base_q   <= '0;
            stride_q <= '0;
            len_q    <= '0;
            off_q    <= '0;
            prio_q   <= '0;
        end else if (cfg_ok) begin
            case (cfg_sel)
                CF_MODE:   begin mode_q <= amode_t'(cfg_wdata[1:0]); off_q <= '0; end
                CF_BASE:   begin base_q <= cfg_wdata[AW-1:0]; off_q <= '0; end
                CF_STRIDE: stride_q <= cfg_wdata[AW-1:0];
                CF_LENGTH: len_q    <= cfg_wdata[AW-1:0];
                CF_PRIO:   prio_q   <= cfg_wdata[PW-1:0];
                default:   ;
            endcase
        end else if (advance) begin
            off_q <= off_nx;
        end
    end

    // offset step per mode
    always_comb begin
        sum    = {1'b0, off_q} + {1'b0, stride_q};
        folded = sum[AW-1:0] - len_q;
        unique case (mode_q)
            AM_STRIDE: off_nx = sum[AW-1:0];
            AM_RING: begin
                if (len_q == '0)                 off_nx = '0;
                else if (sum >= {1'b0, len_q})   off_nx = folded;
                else                             off_nx = sum[AW-1:0];
            end
            default:   off_nx = off_q;
        endcase
    end

    assign op_write = wr_q;
    assign op_wdata = wd_q;
    assign prio     = prio_q;
    assign op_addr  = (mode_q == AM_STRIDE || mode_q == AM_RING) ? (base_q + off_q) : dir_q;

endmodule

// File: rtl/smc_prio_arb.sv
module smc_prio_arb #(
    parameter int NP = 4,
    parameter int PW = 2
) (
    input  logic [NP-1:0]         pending,
    input  logic [NP-1:0][PW-1:0] prio,
    output logic [NP-1:0]         grant
);

    localparam int IW = (NP > 1) ? $clog2(NP) : 1;

    logic          found;
    logic [PW-1:0] best;
    logic [IW-1:0] sel;

    always_comb begin
        found = 1'b0;
        best  = '0;
        sel   = '0;
        for (int i = 0; i < NP; i++) begin
            if (pending[i] && (!found || prio[i] > best)) begin
                found = 1'b1;
                best  = prio[i];
                sel   = IW'(i);
            end
        end
        for (int i = 0; i < NP; i++) begin
            grant[i] = found && (sel == IW'(i));
        end
    end

endmodule

// File: rtl/shmem_ctrl.sv
module shmem_ctrl
    import smc_pkg::*;
#(
    parameter int NP = 4,
    parameter int AW = 13,
    parameter int DW = 16,
    parameter int PW = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NP-1:0]                 req_valid,
    input  logic [NP-1:0]                 req_write,
    input  logic [NP-1:0][AW-1:0]         req_addr,
    input  logic [NP-1:0][DW-1:0]         req_wdata,
    input  logic [NP-1:0]                 cfg_we,
    input  logic [NP-1:0][CFG_SEL_W-1:0]  cfg_sel,
    input  logic [NP-1:0][DW-1:0]         cfg_wdata,
    output logic [NP-1:0]                 busy,
    output logic [NP-1:0]                 gnt,
    output logic [NP-1:0]                 rd_valid,
    output logic [NP-1:0][DW-1:0]         rd_data,
    output logic                          mem_en,
    output logic                          mem_we,
    output logic [AW-1:0]                 mem_addr,
    output logic [DW-1:0]                 mem_wdata,
    input  logic [DW-1:0]                 mem_rdata
);

    logic [NP-1:0]         pending;
    logic [NP-1:0]         op_write;
    logic [NP-1:0][AW-1:0] op_addr;
    logic [NP-1:0][DW-1:0] op_wdata;
    logic [NP-1:0][PW-1:0] prio;

    for (genvar p = 0; p < NP; p++) begin : g_port
        smc_port #(.AW(AW), .DW(DW), .PW(PW)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid[p]),
            .req_write (req_write[p]),
            .req_addr  (req_addr[p]),
            .req_wdata (req_wdata[p]),
            .cfg_we    (cfg_we[p]),
            .cfg_sel   (cfg_sel[p]),
            .cfg_wdata (cfg_wdata[p]),
            .grant     (gnt[p]),
            .pending   (pending[p]),
            .busy      (busy[p]),
            .rd_valid  (rd_valid[p]),
            .op_write  (op_write[p]),
            .op_addr   (op_addr[p]),
            .op_wdata  (op_wdata[p]),
            .prio      (prio[p])
        );
        assign rd_data[p] = rd_valid[p] ? mem_rdata : '0;
    end

    smc_prio_arb #(.NP(NP), .PW(PW)) u_arb (
        .pending (pending),
        .prio    (prio),
        .grant   (gnt)
    );

    assign mem_en = |gnt;

    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        for (int p = 0; p < NP; p++) begin
            if (gnt[p]) begin
                mem_we    = op_write[p];
                mem_addr  = op_addr[p];
                mem_wdata = op_wdata[p];
            end
        end
    end

endmodule

// File: rtl/shmem_ctrl_chk.sv
module shmem_ctrl_chk #(
    parameter int NP = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NP-1:0] gnt,
    input logic [NP-1:0] busy,
    input logic [NP-1:0] rd_valid,
    input logic          mem_we
);

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));

    // R9
    one_rdv_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rd_valid));

    for (genvar p = 0; p < NP; p++) begin : g_chk
        // R2
        gnt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[p] |-> busy[p]);
        // R9
        rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[p] && !mem_we) |=> rd_valid[p]);
        // R9
        rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rd_valid[p]) |-> $past(gnt[p]));
        // R11
        wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[p] && mem_we) |=> !busy[p]);
        // R12
        pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[p] && !gnt[p] && !rd_valid[p]) |=> busy[p]);
    end

endmodule

bind shmem_ctrl shmem_ctrl_chk #(.NP(NP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gnt      (gnt),
    .busy     (busy),
    .rd_valid (rd_valid),
    .mem_we   (mem_we)
);

// File: tb/shmem_ctrl_tb.sv
`timescale 1ns/1ps
module shmem_ctrl_tb;
    localparam int NP = 4;
    localparam int AW = 13;
    localparam int DW = 16;
    localparam int MSK = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0]          req_valid = '0, req_write = '0, cfg_we = '0;
    logic [NP-1:0][AW-1:0]  req_addr = '0;
    logic [NP-1:0][DW-1:0]  req_wdata = '0, cfg_wdata = '0;
    logic [NP-1:0][2:0]     cfg_sel = '0;
    logic [NP-1:0]          busy, gnt, rd_valid;
    logic [NP-1:0][DW-1:0]  rd_data;
    logic                   mem_en, mem_we;
    logic [AW-1:0]          mem_addr;
    logic [DW-1:0]          mem_wdata;
    logic [DW-1:0]          mem_rdata = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    shmem_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .gnt(gnt), .rd_valid(rd_valid),
        .rd_data(rd_data), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // SRAM outside the block
    int  sram[int];
    logic s_en, s_we;
    int  s_addr, s_wd;
    always @(negedge clk) begin
        s_en = mem_en; s_we = mem_we; s_addr = int'(mem_addr); s_wd = int'(mem_wdata);
    end
    always @(posedge clk) begin
        if (s_en === 1'b1) begin
            if (s_we) sram[s_addr] = s_wd;
            else mem_rdata <= sram.exists(s_addr) ? DW'(sram[s_addr]) : '0;
        end
    end

    // behavioural reference model
    int m_state[NP], m_wr[NP], m_dir[NP], m_wd[NP], m_rdata[NP];
    int m_mode[NP], m_base[NP], m_stride[NP], m_len[NP], m_off[NP], m_prio[NP];
    int ref_mem[int];

    function automatic int winner();
        int w = -1;
        for (int p = 0; p < NP; p++)
            if (m_state[p] == 1 && (w < 0 || m_prio[p] > m_prio[w])) w = p;
        return w;
    endfunction

    function automatic int m_addr(int p);
        if (m_mode[p] == 1 || m_mode[p] == 2) return (m_base[p] + m_off[p]) & MSK;
        return m_dir[p];
    endfunction

    task automatic m_advance(int p);
        int s = m_off[p] + m_stride[p];
        if (m_mode[p] == 1) m_off[p] = s & MSK;
        else if (m_mode[p] == 2) begin
            if (m_len[p] == 0) m_off[p] = 0;
            else if (s >= m_len[p]) m_off[p] = (s - m_len[p]) & MSK;
            else m_off[p] = s & MSK;
        end
    endtask

    task automatic m_cfg(int p, int sel, int val);
        case (sel)
            0: begin m_mode[p] = val & 3; m_off[p] = 0; end
            1: begin m_base[p] = val & MSK; m_off[p] = 0; end
            2: m_stride[p] = val & MSK;
            3: m_len[p] = val & MSK;
            4: m_prio[p] = val & 3;
            default: ;
        endcase
    endtask

    always @(posedge clk) begin : model_upd
        int g;
        int a;
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                m_state[p] = 0; m_wr[p] = 0; m_dir[p] = 0; m_wd[p] = 0; m_rdata[p] = 0;
                m_mode[p] = 0; m_base[p] = 0; m_stride[p] = 0; m_len[p] = 0;
                m_off[p] = 0; m_prio[p] = 0;
            end
        end else begin
            g = winner();
            for (int p = 0; p < NP; p++) begin
                case (m_state[p])
                    0: begin
                        if (cfg_we[p] && !req_valid[p]) m_cfg(p, int'(cfg_sel[p]), int'(cfg_wdata[p]));
                        if (req_valid[p]) begin
                            m_wr[p] = int'(req_write[p]); m_dir[p] = int'(req_addr[p]);
                            m_wd[p] = int'(req_wdata[p]); m_state[p] = 1;
                        end
                    end
                    1: if (p == g) begin
                        a = m_addr(p);
                        if (m_wr[p] != 0) begin ref_mem[a] = m_wd[p]; m_state[p] = 0; end
                        else begin
                            m_rdata[p] = ref_mem.exists(a) ? ref_mem[a] : 0;
                            m_state[p] = 2;
                        end
                        m_advance(p);
                    end
                    default: m_state[p] = 0;
                endcase
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    task automatic check_cycle();
        int g = winner();
        int eg = 0, eb = 0, er = 0;
        for (int p = 0; p < NP; p++) begin
            if (m_state[p] != 0) eb |= (1 << p);
            if (m_state[p] == 2) er |= (1 << p);
        end
        if (g >= 0) eg = 1 << g;
        chk("R3 gnt", int'(gnt), eg);
        chk("R2 mem_en", int'(mem_en), (g >= 0) ? 1 : 0);
        chk("R11 R12 busy", int'(busy), eb);
        chk("R9 rd_valid", int'(rd_valid), er);
        for (int p = 0; p < NP; p++)
            chk("R9 rd_data", int'(rd_data[p]), (m_state[p] == 2) ? m_rdata[p] : 0);
        if (g >= 0) begin
            chk("R4 mem_we", int'(mem_we), m_wr[g]);
            if (m_wr[g] != 0) chk("R4 mem_wdata", int'(mem_wdata), m_wd[g]);
            if (m_mode[g] == 1)      chk("R6 mem_addr", int'(mem_addr), m_addr(g));
            else if (m_mode[g] == 2) chk("R7 mem_addr", int'(mem_addr), m_addr(g));
            else                     chk("R5 mem_addr", int'(mem_addr), m_addr(g));
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (rst_n) check_cycle();
        req_valid = '0;
        cfg_we = '0;
    endtask

    task automatic cfg_set(int p, int sel, int val);
        step();
        cfg_we[p] = 1'b1; cfg_sel[p] = 3'(sel); cfg_wdata[p] = DW'(val);
    endtask

    task automatic put_req(int p, bit wr, int addr, int data);
        req_valid[p] = 1'b1; req_write[p] = wr;
        req_addr[p] = AW'(addr); req_wdata[p] = DW'(data);
    endtask

    task automatic do_op(string tag, int p, bit wr, int addr, int data, int exp_addr, int exp_rd);
        step();
        put_req(p, wr, addr, data);
        step();
        chk({tag, " grant"}, int'(gnt[p]), 1);
        chk({tag, " addr"}, int'(mem_addr), exp_addr);
        step();
        if (!wr) begin
            chk("R9 rd_valid", int'(rd_valid[p]), 1);
            chk("R9 rd_data", int'(rd_data[p]), exp_rd);
            step();
        end
        chk("R11 busy", int'(busy[p]), 0);
    endtask

    initial begin
        int ring_exp[6] = '{200, 202, 204, 201, 203, 200};
        int order[4];
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 gnt", int'(gnt), 0);
        chk("R1 rd_valid", int'(rd_valid), 0);
        chk("R1 mem_en", int'(mem_en), 0);

        // R5 direct write and readback on port 0, R9 read return
        do_op("R5", 0, 1'b1, 16, 16'hA5A5, 16, 0);
        do_op("R9", 0, 1'b0, 16, 0, 16, 16'hA5A5);

        // R6 stride mode on port 1
        cfg_set(1, 0, 1); cfg_set(1, 1, 100); cfg_set(1, 2, 3);
        for (int k = 0; k < 4; k++) do_op("R6", 1, 1'b1, 0, 16'h100 + k, 100 + 3 * k, 0);
        do_op("R9", 0, 1'b0, 103, 0, 103, 16'h101);
        // R6 wrap past the top of memory
        cfg_set(1, 1, 8190);
        do_op("R6", 1, 1'b1, 0, 1, 8190, 0);
        do_op("R6", 1, 1'b1, 0, 2, 1, 0);
        do_op("R6", 1, 1'b1, 0, 3, 4, 0);

        // R7 ring mode on port 2
        cfg_set(2, 0, 2); cfg_set(2, 1, 200); cfg_set(2, 2, 2); cfg_set(2, 3, 5);
        for (int k = 0; k < 6; k++) do_op("R7", 2, 1'b1, 0, k, ring_exp[k], 0);
        // R5 reserved mode code behaves as direct
        cfg_set(2, 0, 3);
        do_op("R5", 2, 1'b1, 7, 9, 7, 0);

        // R3 R8 contention, with ignored strobes R10 R12
        cfg_set(1, 1, 500); cfg_set(1, 2, 1);
        cfg_set(2, 0, 2); cfg_set(2, 1, 600);
        cfg_set(3, 0, 1); cfg_set(3, 1, 700); cfg_set(3, 2, 4);
        step();
        for (int p = 0; p < NP; p++) put_req(p, 1'b1, 50, p);
        order = '{50, 500, 600, 700};
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R3 order", int'(gnt), 1 << k);
            chk("R8 addr", int'(mem_addr), order[k]);
            if (k == 1) begin
                cfg_we[3] = 1'b1; cfg_sel[3] = 3'd1; cfg_wdata[3] = 16'd900;
                put_req(2, 1'b1, 0, 77);
            end
        end
        step();
        chk("R12 no extra grant", int'(gnt), 0);
        chk("R11 all idle", int'(busy), 0);
        do_op("R10", 3, 1'b1, 0, 5, 704, 0);
        do_op("R12", 2, 1'b1, 0, 6, 602, 0);

        // R3 priority override
        cfg_set(3, 4, 3); cfg_set(2, 4, 2);
        step();
        for (int p = 0; p < NP; p++) put_req(p, 1'b1, 60, p);
        order = '{8, 4, 1, 2};
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R3 override", int'(gnt), order[k]);
        end

        // R10 strobe together with a request is dropped
        step();
        step();
        put_req(0, 1'b1, 40, 1);
        cfg_we[0] = 1'b1; cfg_sel[0] = 3'd0; cfg_wdata[0] = 16'd1;
        step();
        chk("R10 addr", int'(mem_addr), 40);
        do_op("R10", 0, 1'b1, 41, 2, 41, 0);

        // random traffic against the model
        for (int c = 0; c < 3000; c++) begin
            step();
            for (int p = 0; p < NP; p++) begin
                if ($urandom % 100 < 30)
                    put_req(p, 1'($urandom % 2), int'($urandom % 64), int'($urandom % 65536));
                if ($urandom % 100 < 4) begin
                    int sel = int'($urandom % 8);
                    int val;
                    case (sel)
                        0: val = int'($urandom % 4);
                        1: val = int'($urandom % 64);
                        2: val = int'($urandom % 8);
                        3: val = int'($urandom % 10);
                        4: val = int'($urandom % 4);
                        default: val = int'($urandom % 65536);
                    endcase
                    cfg_we[p] = 1'b1; cfg_sel[p] = 3'(sel); cfg_wdata[p] = DW'(val);
                end
            end
        end
        repeat (4) step();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule